// File: doc/BRIEF.md
# UART Receive Data Register with Character Packing

This block sits between a UART's serial receiver and the processor bus. The receiver hands it one character at a time with a valid strobe and a ninth data bit. The block holds the received data in a 32-bit word that the bus can read. In the default single-character mode each character fills the word by itself. In pack mode two successive characters are combined into one word, so a bus read collects two characters at once.

A single bus address has three jobs, chosen by a divisor-access input that comes from the line-control logic. With that input low, a read returns the receive word and a write sends its low byte to the transmitter. With it high, the same address reads and writes the low byte of the baud divisor. Reading the main address clears the data-ready status. A second, shadow address returns the same receive word but changes no status, which lets debug or polling code look at the data safely. Overrun is flagged when a character arrives while unread data is still pending.

Top module: `uart_rxbuf_regs`

## Requirements
- R1: In single-character mode (pack_en low) an accepted character is placed in bits 7:0 and bits 31:9 read as zero.
- R2: In pack mode (pack_en high) the first accepted character goes to bits 7:0 and the second to bits 23:16. Bits 15:9 and 31:25 always read zero. Storing a first character clears bits 31:16.
- R3: Each character's ninth bit is reported beside it: the lower character's in bit 8 and the upper character's in bit 24.
- R4: In pack mode data_ready rises only once both halves hold a character. After only the first character it stays low.
- R5: With div_access low, a read of the main address (MAIN_ADDR, default 0) returns the receive word and clears data_ready at the next clock edge.
- R6: A read of the shadow address (SHADOW_ADDR, default 2) returns the same word as the main address and leaves data_ready and overrun unchanged.
- R7: With div_access low, a write to the main address raises tx_load for exactly one cycle, in the cycle after the write, with tx_data equal to bus_wdata[7:0].
- R8: With div_access high, the main address reads back as {24'b0, div_low}. A write to it loads div_low from bus_wdata[7:0] and does not raise tx_load. A read of it does not clear data_ready.
- R9: A character that arrives while data_ready is set and is not being read in the same cycle is dropped. The stored word is kept and overrun is set. overrun stays set until reset.
- R10: During and after reset, data_ready, overrun, tx_load, tx_data, div_low and the receive word are all zero.
- R11: Writes to the shadow address are ignored. They cause no tx_load and do not change div_low or the receive word.
- R12: If a destructive read and a new character happen in the same cycle, the read returns the old word, the new character is accepted, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, a combinational function of address and state |
| div_access | input | 1 | Divisor-access select from the line-control logic |
| pack_en | input | 1 | High selects two-character pack mode |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | CHAR_W | Received character |
| rx_bit9 | input | 1 | Ninth data bit of the received character |
| data_ready | output | 1 | A complete word is waiting to be read |
| overrun | output | 1 | Sticky flag: a character was lost |
| tx_load | output | 1 | One-cycle strobe to the transmitter |
| tx_data | output | CHAR_W | Character for the transmitter |
| div_low | output | CHAR_W | Low byte of the baud divisor |

## Verification
The bench drives a read of the main address in the same cycle as a new character arrives. A design that checked overrun before it cleared data_ready would drop that character and set a false overrun. It watches data_ready after only the first character in pack mode; a design that counted characters wrongly would raise it early and return a half-filled word. It reads the shadow address while data is pending, which catches a decoder that lets the shadow read clear status. It also toggles div_access around reads and writes, which shows up a design that sends divisor writes to the transmitter or clears data_ready on a divisor read.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;

    // Read-data source selected by the address decoder
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_RXWORD = 2'd1,
        SEL_DIV    = 2'd2
    } rxb_sel_e;

    // Fixed character width of the data path
    localparam int unsigned CHAR_BITS = 8;

    // Holding state of the receive side
    typedef struct packed {
        logic [CHAR_BITS-1:0] lo_char;
        logic                 lo_b9;
        logic [CHAR_BITS-1:0] hi_char;
        logic                 hi_b9;
        logic                 half;
        logic                 ready;
        logic                 ovr;
    } rxb_state_t;

    // Transmit / divisor side state
    typedef struct packed {
        logic                 load;
        logic [CHAR_BITS-1:0] tdata;
        logic [CHAR_BITS-1:0] dll;
    } txs_state_t;

endpackage

// File: rtl/rxb_decode.sv
module rxb_decode
    import uart_rxbuf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned MAIN_ADDR   = 0,
    parameter int unsigned SHADOW_ADDR = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              div_access,
    output rxb_sel_e          rd_sel,
    output logic              rd_clear,
    output logic              thr_wr,
    output logic              dll_wr
);
    localparam logic [ADDR_W-1:0] MAIN_A   = ADDR_W'(MAIN_ADDR);
    localparam logic [ADDR_W-1:0] SHADOW_A = ADDR_W'(SHADOW_ADDR);

    logic hit_main;
    logic hit_shadow;

    always_comb begin
        hit_main   = (addr == MAIN_A);
        hit_shadow = (addr == SHADOW_A);
        rd_sel     = SEL_NONE;
        if (hit_main)
            rd_sel = div_access ? SEL_DIV : SEL_RXWORD;
        else if (hit_shadow)
            rd_sel = SEL_RXWORD;
        rd_clear = rd & hit_main & ~div_access;
        thr_wr   = wr & hit_main & ~div_access;
        dll_wr   = wr & hit_main &  div_access;
    end

endmodule

// File: rtl/rxb_packer.sv
module rxb_packer
    import uart_rxbuf_pkg::*;
#(
    parameter int unsigned BUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [CHAR_BITS-1:0] rx_char,
    input  logic                 rx_bit9,
    input  logic                 pack_en,
    input  logic                 rd_clear,
    output logic [BUS_W-1:0]     word,
    output logic                 ready,
    output logic                 overrun
);
    localparam int unsigned HI_LSB = BUS_W / 2;
    localparam int unsigned LO_B9  = CHAR_BITS;
    localparam int unsigned HI_B9  = HI_LSB + CHAR_BITS;

    rxb_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.ready = st_q.ready & ~rd_clear;
        if (rx_valid) begin
            if (st_d.ready) begin
                st_d.ovr = 1'b1;
            end else if (!pack_en || !st_q.half) begin
                st_d.lo_char = rx_char;
                st_d.lo_b9   = rx_bit9;
                st_d.hi_char = '0;
                st_d.hi_b9   = 1'b0;
                st_d.half    = pack_en;
                st_d.ready   = ~pack_en;
            end else begin
                st_d.hi_char = rx_char;
                st_d.hi_b9   = rx_bit9;
                st_d.half    = 1'b0;
                st_d.ready   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word                              = '0;
        word[CHAR_BITS-1:0]               = st_q.lo_char;
        word[LO_B9]                       = st_q.lo_b9;
        word[HI_LSB +: CHAR_BITS]         = st_q.hi_char;
        word[HI_B9]                       = st_q.hi_b9;
        ready                             = st_q.ready;
        overrun                           = st_q.ovr;
    end

    // R2
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word[HI_LSB-1:LO_B9+1] == '0) && (word[BUS_W-1:HI_B9+1] == '0));

    // R4
    half_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && pack_en && !st_q.half && !(st_q.ready && !rd_clear)) |=> !ready);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ready && !rd_clear) |=> (overrun && $stable(word)));

endmodule

// File: rtl/rxb_txside.sv
module rxb_txside
    import uart_rxbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 thr_wr,
    input  logic                 dll_wr,
    input  logic [CHAR_BITS-1:0] wbyte,
    output logic                 tx_load,
    output logic [CHAR_BITS-1:0] tx_data,
    output logic [CHAR_BITS-1:0] div_low
);
    txs_state_t ts_q, ts_d;

    always_comb begin
        ts_d      = ts_q;
        ts_d.load = thr_wr;
        if (thr_wr) ts_d.tdata = wbyte;
        if (dll_wr) ts_d.dll   = wbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign tx_load = ts_q.load;
    assign tx_data = ts_q.tdata;
    assign div_low = ts_q.dll;

    // R7
    thr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (tx_load && tx_data == $past(wbyte)));

    // R8
    dll_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_wr && !thr_wr) |=> (!tx_load && div_low == $past(wbyte)));

endmodule

// File: rtl/uart_rxbuf_regs.sv
module uart_rxbuf_regs
    import uart_rxbuf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned BUS_W       = 32,
    parameter int unsigned CHAR_W      = 8,
    parameter int unsigned MAIN_ADDR   = 0,
    parameter int unsigned SHADOW_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              div_access,
    input  logic              pack_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_bit9,
    output logic              data_ready,
    output logic              overrun,
    output logic              tx_load,
    output logic [CHAR_W-1:0] tx_data,
    output logic [CHAR_W-1:0] div_low
);
    rxb_sel_e         rd_sel;
    logic             rd_clear;
    logic             thr_wr;
    logic             dll_wr;
    logic [BUS_W-1:0] rx_word;

    rxb_decode #(
        .ADDR_W      (ADDR_W),
        .MAIN_ADDR   (MAIN_ADDR),
        .SHADOW_ADDR (SHADOW_ADDR)
    ) u_decode (
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .div_access (div_access),
        .rd_sel     (rd_sel),
        .rd_clear   (rd_clear),
        .thr_wr     (thr_wr),
        .dll_wr     (dll_wr)
    );

    rxb_packer #(
        .BUS_W (BUS_W)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .rx_bit9  (rx_bit9),
        .pack_en  (pack_en),
        .rd_clear (rd_clear),
        .word     (rx_word),
        .ready    (data_ready),
        .overrun  (overrun)
    );

    rxb_txside u_txside (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_wr  (thr_wr),
        .dll_wr  (dll_wr),
        .wbyte   (bus_wdata[CHAR_W-1:0]),
        .tx_load (tx_load),
        .tx_data (tx_data),
        .div_low (div_low)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_RXWORD: bus_rdata = rx_word;
            SEL_DIV:    bus_rdata = {{(BUS_W-CHAR_W){1'b0}}, div_low};
            default:    bus_rdata = '0;
        endcase
    end

    // R5
    main_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(MAIN_ADDR) && !div_access && !rx_valid)
            |=> !data_ready);

    // R6
    shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(SHADOW_ADDR) && !rx_valid)
            |=> ($stable(data_ready) && $stable(overrun)));

    // R11
    shadow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SHADOW_ADDR)) |=> !tx_load);

endmodule

// File: tb/uart_rxbuf_regs_bench.sv
`timescale 1ns/1ps
module uart_rxbuf_regs_bench;
    localparam int MAIN = 0;
    localparam int SHAD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        div_access = 1'b0;
    logic        pack_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_bit9 = 1'b0;
    logic        data_ready, overrun, tx_load;
    logic [7:0]  tx_data, div_low;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R10";
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_rxbuf_regs u_uart_rxbuf_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div_access(div_access), .pack_en(pack_en), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_bit9(rx_bit9), .data_ready(data_ready),
        .overrun(overrun), .tx_load(tx_load), .tx_data(tx_data),
        .div_low(div_low)
    );

    // Behavioural reference: characters kept as integers
    int m_lo, m_hi, m_b9lo, m_b9hi, m_pending, m_ready, m_ovr;
    int m_dll, m_txl, m_txd;

    function automatic int m_word();
        return m_lo + (m_b9lo << 8) + (m_hi << 16) + (m_b9hi << 24);
    endfunction

    function automatic int m_rdata();
        if (bus_addr == MAIN) return div_access ? m_dll : m_word();
        if (bus_addr == SHAD) return m_word();
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_b9lo = 0; m_b9hi = 0; m_pending = 0;
            m_ready = 0; m_ovr = 0; m_dll = 0; m_txl = 0; m_txd = 0;
        end else begin
            if (bus_rd && bus_addr == MAIN && !div_access) m_ready = 0;
            if (rx_valid) begin
                if (m_ready) m_ovr = 1;
                else if (pack_en && m_pending) begin
                    m_hi = rx_char; m_b9hi = rx_bit9; m_pending = 0; m_ready = 1;
                end else begin
                    m_lo = rx_char; m_b9lo = rx_bit9; m_hi = 0; m_b9hi = 0;
                    m_pending = pack_en; m_ready = !pack_en;
                end
            end
            m_txl = (bus_wr && bus_addr == MAIN && !div_access);
            if (m_txl) m_txd = bus_wdata[7:0];
            if (bus_wr && bus_addr == MAIN && div_access) m_dll = bus_wdata[7:0];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle, after both model and design have updated
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(bus_rdata == 32'(m_rdata()), {phase, " rdata"}, bus_rdata, m_rdata());
            check(data_ready == m_ready[0], {phase, " data_ready"}, data_ready, m_ready);
            check(overrun == m_ovr[0], {phase, " overrun"}, overrun, m_ovr);
            check(tx_load == m_txl[0], {phase, " tx_load"}, tx_load, m_txl);
            check(tx_data == m_txd[7:0], {phase, " tx_data"}, tx_data, m_txd);
            check(div_low == m_dll[7:0], {phase, " div_low"}, div_low, m_dll);
        end
    end

    task automatic send(input logic [7:0] c, input logic b9);
        @(negedge clk); rx_valid = 1; rx_char = c; rx_bit9 = b9;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = 4'(a);
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk); bus_wr = 1; bus_addr = 4'(a); bus_wdata = v;
        @(negedge clk); bus_wr = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R10 reset values
        check(data_ready == 0 && overrun == 0 && tx_load == 0 && div_low == 0 && tx_data == 0,
              "R10 outputs in reset", {data_ready, overrun, tx_load, div_low}, 0);
        rst_n = 1;
        rd(SHAD, d);
        check(d == 0, "R10 word after reset", d, 0);

        phase = "R1";
        send(8'hA5, 1'b1);
        rd(SHAD, d);
        check(d == 32'h0000_01A5, "R1 R3 shadow single word", d, 32'h1A5);
        check(data_ready == 1, "R6 shadow keeps ready", data_ready, 1);
        phase = "R5";
        rd(MAIN, d);
        check(d == 32'h0000_01A5, "R5 main read word", d, 32'h1A5);
        check(data_ready == 0, "R5 ready cleared", data_ready, 0);

        phase = "R9";
        send(8'h11, 1'b0);
        send(8'h22, 1'b1);
        check(overrun == 1, "R9 overrun set", overrun, 1);
        rd(MAIN, d);
        check(d == 32'h11, "R9 old contents kept", d, 32'h11);
        repeat (2) @(negedge clk);
        check(overrun == 1, "R9 overrun sticky", overrun, 1);

        phase = "R12";
        send(8'h44, 1'b0);
        @(negedge clk); bus_rd = 1; bus_addr = MAIN; rx_valid = 1; rx_char = 8'h55; rx_bit9 = 0;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0; rx_valid = 0;
        check(d == 32'h44, "R12 read returns old", d, 32'h44);
        check(data_ready == 1, "R12 new char accepted", data_ready, 1);
        rd(SHAD, d);
        check(d == 32'h55, "R12 new word", d, 32'h55);
        rd(MAIN, d);

        phase = "R4";
        @(negedge clk); pack_en = 1;
        send(8'h3C, 1'b0);
        check(data_ready == 0, "R4 not ready after first", data_ready, 0);
        send(8'hC3, 1'b1);
        check(data_ready == 1, "R4 ready after second", data_ready, 1);
        phase = "R2";
        rd(SHAD, d);
        check(d == 32'h01C3_003C, "R2 R3 packed word", d, 32'h01C3003C);
        rd(MAIN, d);
        send(8'hFF, 1'b1);
        rd(SHAD, d);
        check(d == 32'h0000_01FF, "R2 first char clears upper", d, 32'h1FF);
        send(8'h80, 1'b0);
        rd(MAIN, d);
        check(d == 32'h0080_01FF, "R2 R3 second pack", d, 32'h008001FF);
        @(negedge clk); pack_en = 0;

        phase = "R7";
        @(negedge clk); bus_wr = 1; bus_addr = MAIN; bus_wdata = 32'hDEAD_BE77;
        @(negedge clk); bus_wr = 0;
        check(tx_load == 1 && tx_data == 8'h77, "R7 strobe and data", {tx_load, tx_data}, 9'h177);
        @(negedge clk);
        check(tx_load == 0, "R7 one cycle only", tx_load, 0);

        phase = "R8";
        send(8'h66, 1'b0);
        @(negedge clk); div_access = 1;
        wr(MAIN, 32'h0000_125A);
        check(div_low == 8'h5A && tx_load == 0, "R8 divisor written", {tx_load, div_low}, 8'h5A);
        rd(MAIN, d);
        check(d == 32'h5A, "R8 divisor read", d, 32'h5A);
        check(data_ready == 1, "R8 read keeps ready", data_ready, 1);
        @(negedge clk); div_access = 0;

        phase = "R11";
        wr(SHAD, 32'h0000_00C7);
        check(tx_load == 0, "R11 no strobe", tx_load, 0);
        check(div_low == 8'h5A, "R11 divisor unchanged", div_low, 8'h5A);
        rd(SHAD, d);
        check(d == 32'h66, "R11 word unchanged", d, 32'h66);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule